// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a down-counting tick timer with a small memory-mapped register set. Software programs a start value, turns the timer on and picks its count source. The source is either every core clock cycle or each rising edge of a slower reference clock. Each time the count steps from one to zero, the timer sets a sticky wrap flag and can pulse a tick interrupt request. The counter then reloads on the next step, so a start value of N gives a period of N+1 steps.

The register port is a plain synchronous bus with address, write strobe, write data, read strobe and read data. Address bits 3:2 pick the register: 0x0 is control/status, 0x4 is the start value, 0x8 is the live count and 0xC is the read-only calibration word. Address bits 1:0 are ignored. A read strobe loads the read-data register on the clock edge, so the data appears one cycle after the strobe. In cycles with no read, the read data is zero. This port has no payload stream, so no valid/ready handshake or back-pressure applies. Every access completes in one cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word, start value and live count all read as zero, and the interrupt request is low.
- R2: With run (control bit 0) and core-clock source (control bit 2) both set, the first step loads the start value from offset 0x4. Each later core cycle decrements it, so a start value R repeats every R+1 cycles.
- R3: The step from 1 to 0 sets the wrap flag, read at control bit 16. A start value of zero never sets the flag and never raises the interrupt.
- R4: When the interrupt-enable bit (control bit 1) is set, each expiry gives exactly one single-cycle high pulse on `tick_irq_o`. When that bit is clear, no pulse occurs but the flag is still set.
- R5: Any read of the control word returns the flag and then clears it. If an expiry happens in the same cycle as that read, the flag stays set.
- R6: A write of any value to offset 0x8 forces the live count to zero and clears the wrap flag.
- R7: With control bit 2 clear, the counter steps once per rising edge of `ref_clk_i`. That edge is detected after a two-flop synchroniser. With no reference edges, the count does not move.
- R8: Offset 0xC holds a fixed calibration word and ignores writes. Bits 23:0 hold the ten-millisecond start value (zero means unknown), bit 30 is the inexact flag, and bit 31 is set when no reference clock is fitted. When no reference clock is fitted, control bit 2 reads 1.
- R9: Read data appears one cycle after the read strobe. Bits with no function read as zero. The start value keeps only bits 23:0 of a write, and the wrap flag cannot be written.
- R10: While run is clear, the live count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous to clk_i |
| bus_addr_i | input | 4 | Byte address within the block |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, one cycle after the strobe |
| tick_irq_o | output | 1 | Single-cycle tick interrupt request |

## Verification
A register write takes effect at the clock edge that samples it, and the counter takes its first step at the next edge. Read data always returns what the register held just before the edge that sampled the strobe. The interrupt pulse is visible in the same cycle in which the count first reads zero. In reference mode, a step lands three core edges after the reference edge, because of the synchroniser flops and the edge detector. The bench drives the bus at falling edges and samples at falling edges. From the edge index at which each strobe is sampled, it derives the expected count, the flag state and the pulse totals.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_CAL  = 2'd3
  } reg_sel_e;

  localparam int BIT_RUN     = 0;
  localparam int BIT_IRQEN   = 1;
  localparam int BIT_CORESRC = 2;
  localparam int BIT_WRAP    = 16;
  localparam int BIT_SKEW    = 30;
  localparam int BIT_NOREF   = 31;
endpackage

// File: rtl/tick_refsync.sv
module tick_refsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= ref_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R7: an edge pulse never lasts two cycles
  assert_ref_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic             clear_i,
  input  logic             wrap_clr_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             wrap_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cur_q;
  logic             wrap_q;
  logic             irq_q;
  logic             advance;
  logic             expire;

  assign advance = run_i & step_i & ~clear_i;
  assign expire  = advance & (cur_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= ZERO;
    end else if (clear_i) begin
      cur_q <= ZERO;
    end else if (advance) begin
      cur_q <= (cur_q == ZERO) ? reload_i : cur_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      wrap_q <= 1'b0;
    else if (expire)                  wrap_q <= 1'b1;
    else if (clear_i || wrap_clr_i)   wrap_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= expire & irq_en_i;
  end

  assign cur_o  = cur_q;
  assign wrap_o = wrap_q;
  assign irq_o  = irq_q;

  // R6: a live-count write leaves zero and no flag
  assert_cur_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cur_o == ZERO) && !wrap_o);
  // R10: stopped counter holds
  assert_hold_when_stopped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(cur_o));
  // R4: request is a single-cycle pulse
  assert_irq_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R3: every request coincides with a set flag and a zero count
  assert_irq_with_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (wrap_o && cur_o == ZERO));
  // R5: coincident clear request never drops a new expiry
  assert_wrap_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_i && !clear_i && cur_o == ONE) |=> wrap_o);
endmodule

// File: rtl/tick_regif.sv
module tick_regif
  import tick_pkg::*;
#(
  parameter int               CNT_W     = 24,
  parameter bit               HAS_REF   = 1'b1,
  parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(99999),
  parameter bit               CAL_SKEW  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [CNT_W-1:0]  cur_i,
  input  logic              wrap_i,
  output logic              run_o,
  output logic              irq_en_o,
  output logic              core_src_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cur_clear_o,
  output logic              wrap_clr_o
);
  localparam int SEL_LSB = 2;

  reg_sel_e          sel;
  logic              run_q, irq_en_q, src_q;
  logic [CNT_W-1:0]  reload_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic [DATA_W-1:0] ctrl_word, cal_word;
  logic              unused_bits;

  assign sel         = reg_sel_e'(bus_addr_i[SEL_LSB+1:SEL_LSB]);
  assign unused_bits = ^{bus_wdata_i[DATA_W-1:CNT_W], bus_addr_i[SEL_LSB-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      irq_en_q <= 1'b0;
      src_q    <= 1'b0;
      reload_q <= '0;
    end else if (bus_wr_i) begin
      if (sel == SEL_CTRL) begin
        run_q    <= bus_wdata_i[BIT_RUN];
        irq_en_q <= bus_wdata_i[BIT_IRQEN];
        src_q    <= bus_wdata_i[BIT_CORESRC];
      end
      if (sel == SEL_LOAD) reload_q <= bus_wdata_i[CNT_W-1:0];
    end
  end

  generate
    if (HAS_REF) begin : g_ref
      assign core_src_o = src_q;
    end else begin : g_noref
      assign core_src_o = 1'b1;
    end
  endgenerate

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[BIT_RUN]     = run_q;
    ctrl_word[BIT_IRQEN]   = irq_en_q;
    ctrl_word[BIT_CORESRC] = core_src_o;
    ctrl_word[BIT_WRAP]    = wrap_i;
    cal_word               = '0;
    cal_word[CNT_W-1:0]    = CAL_TENMS;
    cal_word[BIT_SKEW]     = CAL_SKEW;
    cal_word[BIT_NOREF]    = !HAS_REF;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_LOAD: rd_mux = {{(DATA_W-CNT_W){1'b0}}, reload_q};
      SEL_CUR:  rd_mux = {{(DATA_W-CNT_W){1'b0}}, cur_i};
      default:  rd_mux = cal_word;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
    else               rdata_q <= '0;
  end

  assign bus_rdata_o = rdata_q;
  assign run_o       = run_q;
  assign irq_en_o    = irq_en_q;
  assign reload_o    = reload_q;
  assign cur_clear_o = bus_wr_i && (sel == SEL_CUR);
  assign wrap_clr_o  = bus_rd_i && (sel == SEL_CTRL);

  // R9: control write lands on the next edge
  assert_ctrl_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && sel == SEL_CTRL) |=> (run_o == $past(bus_wdata_i[BIT_RUN])));
  // R9: no register drives bits 29:24
  assert_unused_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[29:24] == 6'd0);
  // R9: idle cycles return zero
  assert_idle_rdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> bus_rdata_o == '0);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int               CNT_W       = 24,
  parameter bit               HAS_REF     = 1'b1,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CAL_TENMS   = CNT_W'(99999),
  parameter bit               CAL_SKEW    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              tick_irq_o
);
  logic             run, irq_en, core_src, cur_clear, wrap_clr, wrap;
  logic             ref_rise, step;
  logic [CNT_W-1:0] reload, cur;

  tick_regif #(
    .CNT_W(CNT_W), .HAS_REF(HAS_REF), .CAL_TENMS(CAL_TENMS), .CAL_SKEW(CAL_SKEW)
  ) u_regif (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rd_i(bus_rd_i), .bus_rdata_o(bus_rdata_o),
    .cur_i(cur), .wrap_i(wrap),
    .run_o(run), .irq_en_o(irq_en), .core_src_o(core_src),
    .reload_o(reload), .cur_clear_o(cur_clear), .wrap_clr_o(wrap_clr)
  );

  tick_refsync #(.STAGES(SYNC_STAGES)) u_refsync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_clk_i), .rise_o(ref_rise)
  );

  assign step = core_src ? 1'b1 : ref_rise;

  tick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(run), .step_i(step), .clear_i(cur_clear), .wrap_clr_i(wrap_clr),
    .irq_en_i(irq_en), .reload_i(reload),
    .cur_o(cur), .wrap_o(wrap), .irq_o(tick_irq_o)
  );
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  localparam logic [3:0] A_CTRL = 4'h0, A_LOAD = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;
  localparam logic [31:0] CAL_EXP = 32'h4001_869F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          vec = 0, bad = 0;

  always #5 clk = ~clk;

  tick_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rd_i(rd), .bus_rdata_o(rdata), .tick_irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // stop, clear count, program start value
  task automatic prep(input logic [31:0] r, input logic [31:0] stop_ctrl);
    bus_write(A_CTRL, stop_ctrl);
    bus_write(A_CUR, 32'h0);
    bus_write(A_LOAD, r);
  endtask

  function automatic logic [31:0] exp_cur(input int r, input int k);
    int m;
    if (r == 0) return 32'h0;
    m = (k - 1) % (r + 1);
    return (m == 0) ? 32'(r) : 32'(r - m);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int cnt, dbl;
    logic prev;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_read(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    bus_read(A_LOAD, v); chk("R1 load", v, 32'h0);
    bus_read(A_CUR, v);  chk("R1 cur", v, 32'h0);

    // R8 calibration word, writes ignored
    bus_read(A_CAL, v); chk("R8 cal", v, CAL_EXP);
    bus_write(A_CAL, 32'hFFFF_FFFF);
    bus_read(A_CAL, v); chk("R8 cal after write", v, CAL_EXP);

    // R9 masking and unwritable flag
    bus_write(A_LOAD, 32'hFFFF_FFFF);
    bus_read(A_LOAD, v); chk("R9 load mask", v, 32'h00FF_FFFF);
    bus_write(A_CTRL, 32'hFFFF_FFF8);
    bus_read(A_CTRL, v); chk("R9 ctrl mask", v, 32'h0);
    @(negedge clk); chk("R9 idle rdata", rdata, 32'h0);

    // R2/R3 random start values and sample points
    for (int t = 0; t < 10; t++) begin
      int r, d;
      r = 1 + int'($urandom % 20);
      d = int'($urandom % 50);
      prep(32'(r), 32'h4);
      bus_write(A_CTRL, 32'h5);
      repeat (d) @(negedge clk);
      bus_read(A_CUR, v);  chk("R2 count", v, exp_cur(r, 1 + d));
      bus_read(A_CTRL, v); chk("R3 flag", v, 32'h5 | ((d + 2 >= r) ? 32'h1_0000 : 32'h0));
    end

    // R5 coincident read keeps flag, then read clears
    prep(32'd3, 32'h4);
    bus_write(A_CTRL, 32'h5);
    repeat (2) @(negedge clk);
    bus_read(A_CTRL, v); chk("R5 read at expiry", v, 32'h5);
    bus_read(A_CTRL, v); chk("R5 flag kept", v, 32'h1_0005);
    bus_write(A_CTRL, 32'h4);
    bus_read(A_CTRL, v); chk("R5 flag again", v, 32'h1_0004);
    bus_read(A_CTRL, v); chk("R5 cleared by read", v, 32'h4);

    // R10 hold while stopped, R6 count write
    prep(32'd5, 32'h4);
    bus_write(A_CTRL, 32'h5);
    repeat (8) @(negedge clk);
    bus_write(A_CTRL, 32'h4);
    bus_read(A_CUR, v); chk("R10 stopped value", v, 32'h2);
    repeat (20) @(negedge clk);
    bus_read(A_CUR, v2); chk("R10 held", v2, 32'h2);
    bus_write(A_CUR, 32'h00AB_CDEF);
    bus_read(A_CUR, v); chk("R6 count zero", v, 32'h0);
    bus_read(A_CTRL, v); chk("R6 flag cleared", v, 32'h4);

    // R4 pulses with interrupt enabled
    prep(32'd3, 32'h4);
    bus_write(A_CTRL, 32'h7);
    cnt = 0; dbl = 0; prev = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq) cnt++;
      if (irq && prev) dbl++;
      prev = irq;
    end
    chk("R4 pulse count", 32'(cnt), 32'd10);
    chk("R4 single cycle", 32'(dbl), 32'd0);

    // R4 interrupt disabled: flag only
    prep(32'd3, 32'h4);
    bus_write(A_CTRL, 32'h5);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq) cnt++;
    end
    chk("R4 no pulse", 32'(cnt), 32'd0);
    bus_read(A_CTRL, v); chk("R4 flag set", v, 32'h1_0005);

    // R3 zero start value never fires
    prep(32'd0, 32'h4);
    bus_write(A_CTRL, 32'h7);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (irq) cnt++;
    end
    chk("R3 zero reload irq", 32'(cnt), 32'd0);
    bus_read(A_CTRL, v); chk("R3 zero reload flag", v, 32'h7);
    bus_read(A_CUR, v);  chk("R3 zero reload count", v, 32'h0);

    // R7 reference clock source
    prep(32'd10, 32'h0);
    bus_write(A_CTRL, 32'h1);
    repeat (10) @(negedge clk);
    bus_read(A_CUR, v); chk("R7 no ref edges", v, 32'h0);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); ref_clk = 1'b1;
      repeat (4) @(negedge clk);
      ref_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    bus_read(A_CUR, v); chk("R7 ref steps", v, 32'd6);
    bus_read(A_CTRL, v); chk("R7 src bit", v, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule